// File: doc/BRIEF.md
# Undo-Logging Memory Controller with Two-Step Checkpoints

This block owns a small word-organised main memory and guards it with an undo log, so that memory can be returned to an earlier committed checkpoint after an error. Each line carries a one-bit "saved" flag. The first write to a line in a checkpoint interval first copies that line's address and old contents into a circular log and only then updates memory. Later writes to the same line in the same interval go straight through.

Checkpoints are committed in two steps. A tentative command closes the running interval and opens a new one. The closed interval's log entries are kept, so that two checkpoints' worth of undo data is held. A final command then frees the older entries. A rollback command walks every retained log entry from newest to oldest and writes the old values back. While a tentative commit is still open, this returns memory to the older, fully committed checkpoint. Commands that arrive while a write is in progress are queued, and they run only after that write has completed.

Top module: `ulc_undo_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `overflow` are low and every memory line reads as zero.
- R2: A read request accepted in a cycle with `busy` low presents the addressed line on `rdata` after the next rising edge.
- R3: A write to a line not yet saved in the current interval writes the log entry first and then the memory line. `busy` is high for exactly the two cycles after the request is accepted, and after that the new value reads back.
- R4: A write to a line already saved in the current interval updates memory at the accepting edge, keeps `busy` low and uses no log entry.
- R5: A tentative command clears every saved flag, so that the next write to any line is logged again. The log entries written before the command are kept.
- R6: A final command issued while a tentative commit is open frees the older log entries. A later rollback then restores memory only as far back as the tentative point.
- R7: A final command with no tentative commit open has no effect on the log. `done` still pulses.
- R8: Rollback replays all retained entries from newest to oldest, clears all saved flags and overflow, then raises `done` for one cycle. A line saved in both retained intervals therefore ends with the older checkpoint's value.
- R9: When the log holds LOG_DEPTH entries, a write that would need a new entry is dropped and `overflow` is set. While `overflow` is high, every write is dropped. A final commit that frees entries, or a rollback, clears `overflow`.
- R10: A command that is pulsed in the same cycle a write is accepted, or while a write is being logged, is held with `busy` high until that write has finished, and it then applies after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Memory request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Line address |
| req_wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| busy | output | 1 | Controller cannot take a request |
| cmd_tentative | input | 1 | One-cycle pulse: open a tentative commit |
| cmd_final | input | 1 | One-cycle pulse: make the tentative commit final |
| cmd_rollback | input | 1 | One-cycle pulse: restore memory from the log |
| done | output | 1 | One-cycle pulse when a command completes |
| overflow | output | 1 | Log full; writes are being dropped |

## Verification
A memory write and a checkpoint command can land on the same clock edge. The bench provokes this by driving a write to an unsaved line together with a command pulse in the same cycle, and separately by pulsing the command one cycle after the write is accepted, while logging is under way. The outcome is judged by where the write ends up. If a concurrent tentative commit is followed by final and rollback and the write survives, the write was logged before the interval closed. If a concurrent rollback leaves the line at its old value, the write completed and was logged before the replay started.

// File: rtl/ulc_pkg.sv
package ulc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOG  = 2'd1,
      ST_WR   = 2'd2,
      ST_RB   = 2'd3
   } ulc_state_e;

   localparam int CMD_TENT = 0;
   localparam int CMD_FIN  = 1;
   localparam int CMD_RB   = 2;
endpackage

// File: rtl/ulc_line_flags.sv
module ulc_line_flags #(
   parameter int LINES = 16,
   localparam int AW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [AW-1:0]    set_idx,
   input  logic             clr_all,
   output logic [LINES-1:0] flags
);
   for (genvar i = 0; i < LINES; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  flags[i] <= 1'b0;
         else if (clr_all)                            flags[i] <= 1'b0;
         else if (set_en && (set_idx == AW'(i)))      flags[i] <= 1'b1;
      end
   end

   AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (flags == '0)); // R5
endmodule

// File: rtl/ulc_log_ram.sv
module ulc_log_ram #(
   parameter int EW    = 12,
   parameter int DEPTH = 8,
   localparam int LA   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [LA-1:0] waddr,
   input  logic [EW-1:0] wentry,
   input  logic [LA-1:0] raddr,
   output logic [EW-1:0] rentry
);
   logic [EW-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slots[waddr] <= wentry;
   end

   assign rentry = slots[raddr];
endmodule

// File: rtl/ulc_data_ram.sv
module ulc_data_ram #(
   parameter int DW    = 8,
   parameter int LINES = 16,
   localparam int AW   = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] words [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) words[i] <= '0;
      end else if (we) begin
         words[waddr] <= wdata;
      end
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/ulc_undo_ctrl.sv
module ulc_undo_ctrl
   import ulc_pkg::*;
#(
   parameter int DW        = 8,
   parameter int LINES     = 16,
   parameter int LOG_DEPTH = 8,
   localparam int AW = $clog2(LINES),
   localparam int LA = $clog2(LOG_DEPTH),
   localparam int PW = LA + 1,
   localparam int EW = AW + DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic [DW-1:0] rdata,
   output logic          busy,
   input  logic          cmd_tentative,
   input  logic          cmd_final,
   input  logic          cmd_rollback,
   output logic          done,
   output logic          overflow
);
   if (LOG_DEPTH < 2 || LOG_DEPTH != (1 << LA)) begin : g_chk_log
      $error("LOG_DEPTH must be a power of two, at least 2");
   end
   if (LINES < 2 || DW < 1) begin : g_chk_mem
      $error("LINES must be at least 2 and DW at least 1");
   end

   ulc_state_e    state;
   logic [PW-1:0] head, tail, mark;
   logic [2:0]    pend;
   logic          tent_open;
   logic [AW-1:0] cap_addr;
   logic [DW-1:0] cap_data;
   logic [LINES-1:0] saved;

   logic [PW-1:0] used;
   logic          log_full, idle_free, take_req, direct_wr, rb_step;
   logic          open_tent, rb_finish, flag_clr;
   logic          mem_we;
   logic [AW-1:0] mem_wa, mem_ra;
   logic [DW-1:0] mem_wd, mem_q;
   logic [LA-1:0] log_ra;
   logic [EW-1:0] log_q;

   assign used      = head - tail;
   assign log_full  = (used == PW'(LOG_DEPTH));
   assign idle_free = (state == ST_IDLE) && (pend == 3'b000);
   assign take_req  = idle_free && req_valid;
   assign direct_wr = take_req && req_write && !overflow && saved[req_addr];
   assign rb_step   = (state == ST_RB) && (head != tail);
   assign rb_finish = (state == ST_RB) && (head == tail);
   assign open_tent = (state == ST_IDLE) && (pend == 3'b001) && !tent_open;
   assign flag_clr  = open_tent || rb_finish;
   assign busy      = (state != ST_IDLE) || (pend != 3'b000);
   assign log_ra    = LA'(head - 1'b1);
   assign mem_ra    = (state == ST_IDLE) ? req_addr : cap_addr;

   always_comb begin
      mem_we = 1'b0;
      mem_wa = req_addr;
      mem_wd = req_wdata;
      if (direct_wr) begin
         mem_we = 1'b1;
      end else if (state == ST_WR) begin
         mem_we = 1'b1;
         mem_wa = cap_addr;
         mem_wd = cap_data;
      end else if (rb_step) begin
         mem_we = 1'b1;
         mem_wa = log_q[EW-1:DW];
         mem_wd = log_q[DW-1:0];
      end
   end

   ulc_data_ram #(.DW(DW), .LINES(LINES)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
      .raddr(mem_ra), .rdata(mem_q));

   ulc_log_ram #(.EW(EW), .DEPTH(LOG_DEPTH)) u_log (
      .clk(clk), .we(state == ST_LOG), .waddr(head[LA-1:0]),
      .wentry({cap_addr, mem_q}), .raddr(log_ra), .rentry(log_q));

   ulc_line_flags #(.LINES(LINES)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_en(state == ST_WR), .set_idx(cap_addr),
      .clr_all(flag_clr), .flags(saved));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         head      <= '0;
         tail      <= '0;
         mark      <= '0;
         pend      <= '0;
         tent_open <= 1'b0;
         overflow  <= 1'b0;
         done      <= 1'b0;
         cap_addr  <= '0;
         cap_data  <= '0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         pend <= pend | {cmd_rollback, cmd_final, cmd_tentative};
         unique case (state)
            ST_IDLE: begin
               if (pend[CMD_RB]) begin
                  pend[CMD_RB] <= 1'b0;
                  state        <= ST_RB;
               end else if (pend[CMD_FIN]) begin
                  pend[CMD_FIN] <= 1'b0;
                  done          <= 1'b1;
                  if (tent_open) begin
                     tail      <= mark;
                     tent_open <= 1'b0;
                     overflow  <= 1'b0;
                  end
               end else if (pend[CMD_TENT]) begin
                  pend[CMD_TENT] <= 1'b0;
                  done           <= 1'b1;
                  if (!tent_open) begin
                     mark      <= head;
                     tent_open <= 1'b1;
                  end
               end else if (take_req) begin
                  if (!req_write) begin
                     rdata <= mem_q;
                  end else if (!overflow && !saved[req_addr]) begin
                     if (log_full) begin
                        overflow <= 1'b1;
                     end else begin
                        cap_addr <= req_addr;
                        cap_data <= req_wdata;
                        state    <= ST_LOG;
                     end
                  end
               end
            end
            ST_LOG: begin
               head  <= head + 1'b1;
               state <= ST_WR;
            end
            ST_WR: state <= ST_IDLE;
            ST_RB: begin
               if (head != tail) begin
                  head <= head - 1'b1;
               end else begin
                  mark      <= tail;
                  tent_open <= 1'b0;
                  overflow  <= 1'b0;
                  done      <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_LOG_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR) |-> (head == PW'($past(head) + 1'b1))); // R3
   AST_LOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (used <= PW'(LOG_DEPTH))); // R9
   AST_NO_WRITE_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && state == ST_IDLE) |-> !mem_we); // R9
   AST_TAIL_ONLY_BY_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(tail)); // R6
   AST_WRITE_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOG) |=> (state == ST_WR)); // R10
endmodule

// File: tb/ulc_undo_ctrl_test.sv
`timescale 1ns/1ps
module ulc_undo_ctrl_test;
   localparam int DW = 8;
   localparam int LINES = 16;
   localparam int LOG_DEPTH = 8;
   localparam int AW = $clog2(LINES);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rdata;
   logic          busy, done, overflow;
   logic          cmd_tentative = 1'b0, cmd_final = 1'b0, cmd_rollback = 1'b0;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   ulc_undo_ctrl #(.DW(DW), .LINES(LINES), .LOG_DEPTH(LOG_DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .busy(busy),
      .cmd_tentative(cmd_tentative), .cmd_final(cmd_final), .cmd_rollback(cmd_rollback),
      .done(done), .overflow(overflow));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic do_write(input int a, input int d, output int bcyc);
      wait_idle();
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = DW'(d);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      bcyc = 0;
      while (busy && bcyc < 50) begin bcyc++; @(negedge clk); end
   endtask

   task automatic do_read(input int a, output int d);
      wait_idle();
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
      @(negedge clk);
      req_valid = 1'b0;
      d = int'(rdata);
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 100) begin n++; @(negedge clk); end
      check(done, req, done, 1);
      @(negedge clk);
      check(!done, req, done, 0);
   endtask

   task automatic pulse_cmd(input int which, input string req);
      wait_idle();
      if (which == 0) cmd_tentative = 1'b1;
      else if (which == 1) cmd_final = 1'b1;
      else cmd_rollback = 1'b1;
      @(negedge clk);
      cmd_tentative = 1'b0; cmd_final = 1'b0; cmd_rollback = 1'b0;
      wait_done(req);
   endtask

   task automatic expect_line(input int a, input int exp, input string req);
      int v;
      do_read(a, v);
      check(v == exp, req, v, exp);
   endtask

   task automatic t_reset();
      check(!busy && !done && !overflow, "R1", {busy, done, overflow}, 0);
      expect_line(5, 0, "R1");
      expect_line(15, 0, "R1");
   endtask

   task automatic t_basic();
      int bc;
      do_write(2, 'h11, bc);
      check(bc == 2, "R3 busy cycles", bc, 2);
      expect_line(2, 'h11, "R2");
      do_write(2, 'h22, bc);
      check(bc == 0, "R4 busy cycles", bc, 0);
      expect_line(2, 'h22, "R4");
   endtask

   task automatic t_rollback();
      int bc;
      do_write(4, 'h44, bc);
      pulse_cmd(2, "R8 done");
      expect_line(2, 0, "R8");
      expect_line(4, 0, "R8");
      do_write(4, 'h45, bc);
      check(bc == 2, "R8 flags cleared", bc, 2);
      pulse_cmd(2, "R8 done");
   endtask

   task automatic t_commit();
      int bc;
      do_write(3, 'h33, bc);
      pulse_cmd(0, "R5 done");
      pulse_cmd(1, "R6 done");
      do_write(3, 'h99, bc);
      pulse_cmd(2, "R6 done");
      expect_line(3, 'h33, "R6");
   endtask

   task automatic t_two_ckpt();
      int bc;
      do_write(6, 'h01, bc);
      pulse_cmd(0, "R5 done");
      do_write(6, 'h02, bc);
      check(bc == 2, "R5 relogged", bc, 2);
      pulse_cmd(2, "R8 done");
      expect_line(6, 0, "R8 newest-to-oldest");
      expect_line(3, 'h33, "R8");
   endtask

   task automatic t_final_alone();
      int bc;
      do_write(7, 'h77, bc);
      pulse_cmd(1, "R7 done");
      pulse_cmd(2, "R7 done");
      expect_line(7, 0, "R7");
   endtask

   task automatic t_overflow();
      int bc;
      pulse_cmd(0, "R9 done");
      pulse_cmd(1, "R9 done");
      for (int i = 0; i < LOG_DEPTH; i++) do_write(i, 'h50 + i, bc);
      check(!overflow, "R9 not yet", overflow, 0);
      do_write(8, 'hAB, bc);
      check(overflow, "R9 set", overflow, 1);
      expect_line(8, 0, "R9 dropped");
      do_write(0, 'hEE, bc);
      expect_line(0, 'h50, "R9 dropped saved");
      pulse_cmd(0, "R9 done");
      pulse_cmd(1, "R9 done");
      check(!overflow, "R9 cleared", overflow, 0);
      do_write(8, 'hAB, bc);
      expect_line(8, 'hAB, "R9 accepted");
   endtask

   task automatic t_concurrent();
      int bc;
      pulse_cmd(0, "R10 done");
      pulse_cmd(1, "R10 done");
      wait_idle();
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(10); req_wdata = 'h5A;
      cmd_rollback = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; cmd_rollback = 1'b0;
      check(busy, "R10 held busy", busy, 1);
      wait_done("R10 done");
      expect_line(10, 0, "R10 rollback after write");
      wait_idle();
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(11); req_wdata = 'h6B;
      cmd_tentative = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; cmd_tentative = 1'b0;
      wait_done("R10 done");
      pulse_cmd(1, "R10 done");
      pulse_cmd(2, "R10 done");
      expect_line(11, 'h6B, "R10 write before tentative");
      wait_idle();
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(12); req_wdata = 'h12;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      cmd_rollback = 1'b1;
      @(negedge clk);
      cmd_rollback = 1'b0;
      check(busy, "R10 busy while logging", busy, 1);
      wait_done("R10 done");
      expect_line(12, 0, "R10 command during logging");
      bc = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_rollback();
      t_commit();
      t_two_ckpt();
      t_final_alone();
      t_overflow();
      t_concurrent();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule